// File: doc/BRIEF.md
# Smartcard Line Character Transmitter

This block sends one character at a time over a single shared half-duplex wire of the kind used to talk to a smart card. A character is a low start bit, eight data bits least-significant first, an even parity bit and a released stop period of one and a half bit times. The wire is open-drain. The block only ever pulls it low, and it reads the wire back through a separate input so that it can see the card answer during the stop period.

Bit timing comes from an external sub-bit tick. `OVS` ticks make one bit period, and a free-running phase counter marks the baud edges. A byte is taken through a valid/ready port. Shifting starts half a bit period after the first baud edge that follows acceptance. If the card holds the wire low at the middle of the first stop bit, the block raises a framing-error flag. The transmit-complete flag is withheld for a programmable number of bit periods after the stop period so that the card gets its guard time. Retransmission is left to the controlling logic.

Top module: `iso_card_tx`

## Requirements
- R1: During and right after reset, `line_o` is 1 (released), `tc` is 1, `frame_err` is 0 and `wr_ready` equals `tx_en`.
- R2: A byte is accepted on a clock edge where `wr_valid` and `wr_ready` are both 1. In the cycle after acceptance, `tc` and `frame_err` read 0.
- R3: Ticks are counted from reset. A baud edge is the tick that brings the count to a multiple of `OVS`. The start bit begins exactly `OVS/2` ticks after the first baud edge that follows acceptance.
- R4: The frame is a start bit (0), then data bits 0 to 7 in that order, then a parity bit equal to the XOR of the eight data bits (even parity). Each of these lasts `OVS` ticks.
- R5: After the parity bit, `line_o` stays 1 for a stop period of `3*OVS/2` ticks.
- R6: `line_i` is sampled at the tick that completes the first `OVS/2` ticks of the stop period. A 0 there sets `frame_err`, which holds until the next acceptance.
- R7: A low `line_i` outside that sample point does not start a frame, does not drive the line and does not change the `tc` timing. A card NACK of one or two bit periods is never taken as a start bit.
- R8: `guard_len` is captured at acceptance. `tc` rises exactly `guard_len*OVS` ticks after the stop period ends, or at its end when `guard_len` is 0, and stays low until then.
- R9: While `tx_en` is 0, `wr_ready` is 0 and writes are ignored: the line stays released and `tc` stays 1.
- R10: From acceptance until `tc` rises, `wr_ready` is 0. A write offered in that time is dropped and does not alter the character on the wire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable; gates acceptance of new bytes |
| tick | input | 1 | Sub-bit timing strobe, `OVS` per bit period |
| wr_valid | input | 1 | Write request |
| wr_data | input | DW (8) | Byte to send |
| wr_ready | output | 1 | Ready to accept a byte |
| guard_len | input | GW (8) | Guard time in bit periods, captured on acceptance |
| line_i | input | 1 | Wire level read back |
| line_o | output | 1 | Open-drain drive: 0 pulls low, 1 releases |
| tc | output | 1 | Transmit complete, delayed by guard time |
| frame_err | output | 1 | Card NACK seen in the stop period |

## Verification
A wrong phase or sub-bit count shows up on the first character. The start bit lands away from half a bit after a baud edge, or a mid-bit sample of data or parity reads the wrong level within about ten bit periods. A wrong guard counter, or a stop period of the wrong length, moves the rising edge of `tc` by at least one tick, and that edge is checked on the exact tick and the tick before it. A NACK sampler at the wrong point, or a sampler that stays armed, shows as a wrong `frame_err` level as soon as `tc` rises, because the bench holds the card low for one or two bit periods and also leaves it high.

// File: rtl/iso_card_tx_pkg.sv
package iso_card_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SYNC,
      ST_HALF,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_GUARD
   } tx_state_t;

endpackage

// File: rtl/iso_card_tx_phase.sv
module iso_card_tx_phase #(
   parameter int OVS = 16,
   localparam int SW = $clog2(OVS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   output logic          baud_edge,
   output logic [SW-1:0] phase
);

   localparam logic [SW-1:0] PH_LAST = SW'(OVS - 1);

   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("iso_card_tx_phase: OVS must be even and at least 4");
   end

   assign baud_edge = tick && (phase == PH_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
      end else if (tick) begin
         phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
      end
   end

   // R3
   phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      baud_edge |=> phase == '0);

endmodule

// File: rtl/iso_card_tx_shreg.sv
module iso_card_tx_shreg #(
   parameter int DW         = 8,
   parameter bit MSB_FIRST  = 1'b0,
   parameter bit ODD_PARITY = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] data,
   input  logic          shift,
   output logic          bit_o,
   output logic          par_o
);

   logic [DW-1:0] sh_q;
   logic          par_q;

   if (DW < 2) begin : g_bad_dw
      $error("iso_card_tx_shreg: DW must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_q <= 1'b0;
      end else if (load) begin
         par_q <= (^data) ^ ODD_PARITY;
      end
   end

   if (MSB_FIRST) begin : g_msb
      assign bit_o = sh_q[DW-1];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_q <= '0;
         end else if (load) begin
            sh_q <= data;
         end else if (shift) begin
            sh_q <= {sh_q[DW-2:0], 1'b0};
         end
      end
   end else begin : g_lsb
      assign bit_o = sh_q[0];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_q <= '0;
         end else if (load) begin
            sh_q <= data;
         end else if (shift) begin
            sh_q <= {1'b0, sh_q[DW-1:1]};
         end
      end
   end

   assign par_o = par_q;

   // R4
   parity_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> par_o == ((^$past(data)) ^ ODD_PARITY));

endmodule

// File: rtl/iso_card_tx_guard.sv
module iso_card_tx_guard #(
   parameter int OVS = 16,
   parameter int GW  = 8,
   localparam int SW = $clog2(OVS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          tick,
   input  logic [GW-1:0] limit,
   output logic          done
);

   localparam logic [SW-1:0] SUB_LAST = SW'(OVS - 1);

   logic          run_q;
   logic [SW-1:0] sub_q;
   logic [GW-1:0] per_q;

   if (GW < 1) begin : g_bad_gw
      $error("iso_card_tx_guard: GW must be at least 1");
   end

   assign done = run_q && tick && (sub_q == SUB_LAST) && (per_q == limit - GW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         sub_q <= '0;
         per_q <= '0;
      end else if (start) begin
         run_q <= 1'b1;
         sub_q <= '0;
         per_q <= '0;
      end else if (run_q && tick) begin
         if (sub_q == SUB_LAST) begin
            sub_q <= '0;
            if (done) run_q <= 1'b0;
            else      per_q <= per_q + 1'b1;
         end else begin
            sub_q <= sub_q + 1'b1;
         end
      end
   end

   // R8
   guard_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> per_q < limit);

endmodule

// File: rtl/iso_card_tx.sv
module iso_card_tx
   import iso_card_tx_pkg::*;
#(
   parameter int OVS        = 16,
   parameter int DW         = 8,
   parameter int GW         = 8,
   parameter bit MSB_FIRST  = 1'b0,
   parameter bit ODD_PARITY = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tx_en,
   input  logic          tick,
   input  logic          wr_valid,
   input  logic [DW-1:0] wr_data,
   output logic          wr_ready,
   input  logic [GW-1:0] guard_len,
   input  logic          line_i,
   output logic          line_o,
   output logic          tc,
   output logic          frame_err
);

   localparam int SW = $clog2(OVS);
   localparam int CW = $clog2(3 * OVS / 2);
   localparam int NW = $clog2(DW);
   localparam logic [CW-1:0] HALF_LAST = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] BIT_LAST  = CW'(OVS - 1);
   localparam logic [CW-1:0] STOP_LAST = CW'(3 * OVS / 2 - 1);
   localparam logic [NW-1:0] NBIT_LAST = NW'(DW - 1);
   localparam logic [SW-1:0] PH_MID    = SW'(OVS / 2);

   tx_state_t     st_q;
   logic [CW-1:0] cnt_q;
   logic [NW-1:0] nbit_q;
   logic [GW-1:0] guard_q;
   logic          tc_q;
   logic          ferr_q;

   logic          accept;
   logic          baud_edge;
   logic [SW-1:0] phase;
   logic          shift;
   logic          cur_bit;
   logic          par_bit;
   logic          stop_end;
   logic          guard_start;
   logic          guard_done;
   logic          sample_stb;
   logic          drive_low;

   assign wr_ready    = (st_q == ST_IDLE) && tx_en;
   assign accept      = wr_valid && wr_ready;
   assign shift       = (st_q == ST_DATA) && tick && (cnt_q == BIT_LAST);
   assign stop_end    = (st_q == ST_STOP) && tick && (cnt_q == STOP_LAST);
   assign guard_start = stop_end && (guard_q != '0);
   assign sample_stb  = (st_q == ST_STOP) && tick && (cnt_q == HALF_LAST);

   iso_card_tx_phase #(.OVS(OVS)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .baud_edge (baud_edge),
      .phase     (phase)
   );

   iso_card_tx_shreg #(
      .DW         (DW),
      .MSB_FIRST  (MSB_FIRST),
      .ODD_PARITY (ODD_PARITY)
   ) u_shreg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .data  (wr_data),
      .shift (shift),
      .bit_o (cur_bit),
      .par_o (par_bit)
   );

   iso_card_tx_guard #(.OVS(OVS), .GW(GW)) u_guard (
      .clk   (clk),
      .rst_n (rst_n),
      .start (guard_start),
      .tick  (tick),
      .limit (guard_q),
      .done  (guard_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cnt_q   <= '0;
         nbit_q  <= '0;
         guard_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  st_q    <= ST_SYNC;
                  guard_q <= guard_len;
               end
            end
            ST_SYNC: begin
               if (baud_edge) begin
                  st_q  <= ST_HALF;
                  cnt_q <= '0;
               end
            end
            ST_HALF: begin
               if (tick) begin
                  if (cnt_q == HALF_LAST) begin
                     st_q  <= ST_START;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_START: begin
               if (tick) begin
                  if (cnt_q == BIT_LAST) begin
                     st_q   <= ST_DATA;
                     cnt_q  <= '0;
                     nbit_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_DATA: begin
               if (tick) begin
                  if (cnt_q == BIT_LAST) begin
                     cnt_q <= '0;
                     if (nbit_q == NBIT_LAST) st_q <= ST_PAR;
                     else                      nbit_q <= nbit_q + 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_PAR: begin
               if (tick) begin
                  if (cnt_q == BIT_LAST) begin
                     st_q  <= ST_STOP;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_STOP: begin
               if (tick) begin
                  if (stop_end) begin
                     cnt_q <= '0;
                     st_q  <= (guard_q == '0) ? ST_IDLE : ST_GUARD;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_GUARD: begin
               if (guard_done) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tc_q   <= 1'b1;
         ferr_q <= 1'b0;
      end else begin
         if (accept) begin
            tc_q   <= 1'b0;
            ferr_q <= 1'b0;
         end else begin
            if ((stop_end && guard_q == '0) || (st_q == ST_GUARD && guard_done))
               tc_q <= 1'b1;
            if (sample_stb && !line_i)
               ferr_q <= 1'b1;
         end
      end
   end

   always_comb begin
      unique case (st_q)
         ST_START: drive_low = 1'b1;
         ST_DATA:  drive_low = !cur_bit;
         ST_PAR:   drive_low = !par_bit;
         default:  drive_low = 1'b0;
      endcase
   end

   assign line_o    = !drive_low;
   assign tc        = tc_q;
   assign frame_err = ferr_q;

   // R2
   tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !tc && !frame_err);

   // R3
   start_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HALF && tick && cnt_q == HALF_LAST) |=> phase == PH_MID);

   // R6
   nack_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_err) |-> $past(sample_stb) && !$past(line_i));

   // R7
   guard_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_GUARD) |-> line_o && !tc);

   // R8
   tc_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> line_o);

   // R10
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tc |-> !wr_ready);

endmodule

// File: tb/iso_card_tx_tb.sv
`timescale 1ns/1ps
module iso_card_tx_tb;

   localparam int OVS = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_en = 1'b1;
   logic       tick = 1'b0;
   logic       wr_valid = 1'b0;
   logic [7:0] wr_data = '0;
   logic       wr_ready;
   logic [7:0] guard_len = '0;
   logic       line_i;
   logic       line_o;
   logic       tc;
   logic       frame_err;

   int tk = 0;
   int nack_from = 0;
   int nack_to = 0;
   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   assign line_i = line_o & ~((tk >= nack_from) && (tk < nack_to));

   iso_card_tx u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_en     (tx_en),
      .tick      (tick),
      .wr_valid  (wr_valid),
      .wr_data   (wr_data),
      .wr_ready  (wr_ready),
      .guard_len (guard_len),
      .line_i    (line_i),
      .line_o    (line_o),
      .tc        (tc),
      .frame_err (frame_err)
   );

   always @(negedge clk) tick <= rst_n ? 1'($urandom % 2) : 1'b0;
   always @(posedge clk) if (tick) tk <= tk + 1;

   function automatic logic exp_bit(input logic [7:0] d, input int k);
      if (k == 0) return 1'b0;
      if (k <= 8) return d[k-1];
      if (k == 9) return ^d;
      return 1'b1;
   endfunction

   function automatic int exp_start(input int a);
      return a + (OVS - (a % OVS)) + OVS / 2;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at tick %0d", req, act, exp, tk);
      end
   endtask

   task automatic wait_tk(input int t);
      while (tk < t) @(negedge clk);
   endtask

   task automatic summary;
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic send(input logic [7:0] d, input logic [7:0] g, input int nack_len, input bit poke);
      int a, t, e;
      while (!wr_ready) @(negedge clk);
      wr_valid = 1'b1; wr_data = d; guard_len = g;
      @(negedge clk);
      wr_valid = 1'b0;
      a = tk;
      guard_len = 8'($urandom);
      chk(tc == 1'b0 && frame_err == 1'b0, "R2 flags clear", {tc, frame_err}, 0);
      while (line_o) @(negedge clk);
      t = tk;
      chk(t == exp_start(a), "R3 start delay", t, exp_start(a));
      nack_from = t + 10 * OVS;
      nack_to   = nack_from + nack_len * OVS;
      if (poke) begin
         for (int i = 0; i < 3; i++) begin
            wr_valid = 1'b1; wr_data = ~d;
            @(negedge clk);
            chk(wr_ready == 1'b0, "R10 busy ready", wr_ready, 0);
         end
         wr_valid = 1'b0;
      end
      for (int k = 1; k <= 10; k++) begin
         wait_tk(t + k * OVS + OVS / 2);
         chk(line_o == exp_bit(d, k), (k <= 9) ? "R4 frame bit" : "R5 stop", line_o, exp_bit(d, k));
      end
      wait_tk(t + 11 * OVS + OVS / 4);
      chk(line_o == 1'b1, "R5 stop tail", line_o, 1);
      e = t + 10 * OVS + 3 * OVS / 2 + int'(g) * OVS;
      wait_tk(e - 1);
      chk(tc == 1'b0, "R8 tc held", tc, 0);
      wait_tk(e);
      chk(tc == 1'b1, "R8 tc rise", tc, 1);
      chk(frame_err == (nack_len > 0), "R6 nack flag", frame_err, int'(nack_len > 0));
      wait_tk(nack_to);
      nack_from = 0; nack_to = 0;
      begin
         bit quiet = 1'b1;
         for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (!line_o || !tc) quiet = 1'b0;
         end
         chk(quiet, "R7 no restart", quiet, 1);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", tk, 0);
      summary();
   end

   initial begin
      void'($urandom(32'd7319));
      repeat (4) @(negedge clk);
      chk(line_o == 1'b1 && tc == 1'b1 && frame_err == 1'b0, "R1 in reset",
          {line_o, tc, frame_err}, 3'b110);
      rst_n = 1'b1;
      @(negedge clk);
      chk(line_o && tc && !frame_err && wr_ready == tx_en, "R1 after reset",
          {line_o, tc, frame_err, wr_ready}, 4'b1101);

      // R9: writes ignored while disabled
      tx_en = 1'b0;
      begin
         bit ok = 1'b1;
         for (int i = 0; i < 60; i++) begin
            wr_valid = 1'b1; wr_data = 8'h3C;
            @(negedge clk);
            if (wr_ready || !line_o || !tc) ok = 1'b0;
         end
         wr_valid = 1'b0;
         chk(ok, "R9 disabled", ok, 1);
      end
      tx_en = 1'b1;
      @(negedge clk);

      send(8'h00, 8'd0, 0, 1'b0);
      send(8'hFF, 8'd1, 1, 1'b0);
      send(8'h01, 8'd0, 2, 1'b0);
      send(8'hA5, 8'd255, 2, 1'b1);
      send(8'h80, 8'd3, 0, 1'b1);

      for (int n = 0; n < 24; n++) begin
         logic [7:0] d = 8'($urandom);
         logic [7:0] g = 8'($urandom % 6);
         int nl = (($urandom % 4) == 0) ? 1 + int'($urandom % 2) : 0;
         bit pk = (($urandom % 5) == 0);
         send(d, g, nl, pk);
      end

      summary();
   end

endmodule